// File: doc/BRIEF.md
# DMA Channel Register File

This block holds the software-visible state of one DMA channel: a control and status word, the running transfer address, a scratch word and a base-address word. A host reaches the four 32-bit registers through a simple single-cycle register bus that only accepts full, aligned words. The data mover, any address translation and the attached peripheral sit outside; they see the channel through a few dedicated signals.

The control word has side effects. A write can send a one-cycle reset pulse to the peripheral. It also handles the drain bit automatically and moves the DMA-enable level seen by the peripheral when the enable bit changes. A pending-interrupt flag follows the peripheral's interrupt line, and the interrupt enable bit gates it onto the channel's interrupt output. The address register can be loaded from the bus, which raises an "address loaded" status bit. It is also advanced by the data mover after each completed transfer.

Top module: `dma_chan_regs`

## Requirements
- R1: After reset the control word reads 0xA0000000, the other three registers read 0, and `irq_out`, `periph_rst` and `dma_en_out` are low.
- R2: Address bits [3:2] pick the register (0 control, 1 current address, 2 scratch, 3 base). An access counts only with all four strobes set and address bits [1:0] zero. Other writes change nothing, and other reads return 0. Reads have no side effects. Writes to registers 2 and 3 store all 32 bits, and register 3 also drives `base_addr`.
- R3: Control bit 0 (interrupt pending) takes the value `dev_irq_in` had at the previous clock edge.
- R4: `irq_out` is high exactly when control bit 0 and control bit 4 (interrupt enable) are both set. Clearing bit 4 by a write drops `irq_out` in the cycle after that write.
- R5: A control write with bit 7 set drives `periph_rst` high for the single cycle that follows the write.
- R6: On a control write with bit 7 clear, a set bit 6 (drain) is stored as 0. A written value of exactly zero stores bit 6 as 1. With bit 7 set, bit 6 is stored as written.
- R7: `dma_en_out` rises after a control write that takes bit 9 from 0 to 1 and falls after one that takes it from 1 to 0. Otherwise it holds.
- R8: Control bits under mask 0xFE000007 ignore bus writes and keep their value. Bits 31 and 29 (0xA0000000) always read as 1.
- R9: Any accepted write to register 1 sets control bit 26 (address loaded). Bit 26 then stays set until reset.
- R10: A cycle with `xfer_done` high adds the zero-extended `xfer_len` to register 1.
- R11: When a bus write to register 1 and `xfer_done` fall in the same cycle, register 1 takes the bus value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_en | input | 1 | Register access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte address of the access |
| bus_strb | input | 4 | Byte strobes; all must be set |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| dev_irq_in | input | 1 | Interrupt line from the peripheral |
| irq_out | output | 1 | Gated channel interrupt |
| periph_rst | output | 1 | One-cycle peripheral reset pulse |
| dma_en_out | output | 1 | DMA-enable level to the peripheral |
| xfer_done | input | 1 | A transfer completed this cycle |
| xfer_len | input | 16 | Byte count of the completed transfer |
| cur_addr | output | 32 | Current transfer address (register 1) |
| base_addr | output | 32 | Base address (register 3) |

## Verification
The assertions check several things on every cycle. Every rise of the interrupt output follows a high device line, and every reset pulse follows a control write carrying bit 7. The enable level and the address register hold in cycles with no cause to change. A write to the address register beats a concurrent advance and sets the loaded bit. The version bits never drop. Only the bench's scenarios can show the exact stored control words: the drain rule with its zero-value special case, the read-only bits keeping old contents, and partial-strobe writes leaving registers alone. They also show the advance arithmetic over several transfers.

// File: rtl/dma_regs_pkg.sv
package dma_regs_pkg;

   localparam int NUM_REGS  = 4;
   localparam int SEL_W     = $clog2(NUM_REGS);
   localparam int BUS_ADDR_W = SEL_W + 2;

   typedef enum logic [SEL_W-1:0] {
      REG_CTRL    = 2'd0,
      REG_CURADDR = 2'd1,
      REG_SCRATCH = 2'd2,
      REG_BASE    = 2'd3
   } reg_sel_e;

   localparam int B_PEND   = 0;
   localparam int B_IEN    = 4;
   localparam int B_DRAIN  = 6;
   localparam int B_PRST   = 7;
   localparam int B_DMAEN  = 9;
   localparam int B_LOADED = 26;

   localparam logic [31:0] CTRL_VERSION = 32'hA000_0000;
   localparam logic [31:0] CTRL_RO_MASK = 32'hFE00_0007;

   // Apply the drain rule to a written control value.
   function automatic logic [31:0] drain_fix(input logic [31:0] v);
      logic [31:0] r;
      r = v;
      if (!v[B_PRST]) begin
         if (v[B_DRAIN])      r[B_DRAIN] = 1'b0;
         else if (v == '0)    r[B_DRAIN] = 1'b1;
      end
      return r;
   endfunction

endpackage

// File: rtl/dma_ctrl_reg.sv
module dma_ctrl_reg
   import dma_regs_pkg::*;
#(
   parameter int          DATA_W  = 32,
   parameter logic [31:0] VERSION = CTRL_VERSION,
   parameter logic [31:0] RO_MASK = CTRL_RO_MASK
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              dev_irq,
   input  logic              loaded_set,
   output logic [DATA_W-1:0] ctrl_q,
   output logic              irq_out,
   output logic              periph_rst,
   output logic              dma_en
);

   logic [DATA_W-1:0] fixed_w;
   logic [DATA_W-1:0] ctrl_d;
   logic              en_rise;
   logic              en_fall;

   always_comb begin
      fixed_w = drain_fix(wdata);
      ctrl_d  = ctrl_q;
      if (wr) begin
         ctrl_d = (ctrl_q & RO_MASK) | (fixed_w & ~RO_MASK) | VERSION;
      end
      if (loaded_set) ctrl_d[B_LOADED] = 1'b1;
      ctrl_d[B_PEND] = dev_irq;
   end

   assign en_rise = wr &&  wdata[B_DMAEN] && !ctrl_q[B_DMAEN];
   assign en_fall = wr && !wdata[B_DMAEN] &&  ctrl_q[B_DMAEN];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q     <= VERSION;
         periph_rst <= 1'b0;
         dma_en     <= 1'b0;
      end else begin
         ctrl_q     <= ctrl_d;
         periph_rst <= wr && wdata[B_PRST];
         if (en_rise)      dma_en <= 1'b1;
         else if (en_fall) dma_en <= 1'b0;
      end
   end

   assign irq_out = ctrl_q[B_PEND] & ctrl_q[B_IEN];

endmodule

// File: rtl/dma_addr_ctr.sv
module dma_addr_ctr #(
   parameter int DATA_W = 32,
   parameter int LEN_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              adv,
   input  logic [LEN_W-1:0]  adv_len,
   output logic [DATA_W-1:0] addr_q
);

   localparam int PAD_W = DATA_W - LEN_W;

   logic [DATA_W-1:0] step;

   generate
      if (PAD_W > 0) begin : g_pad
         assign step = {{PAD_W{1'b0}}, adv_len};
      end else begin : g_nopad
         assign step = adv_len[DATA_W-1:0];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)   addr_q <= '0;
      else if (wr)  addr_q <= wdata;
      else if (adv) addr_q <= addr_q + step;
   end

endmodule

// File: rtl/dma_store_regs.sv
module dma_store_regs #(
   parameter int DATA_W = 32,
   parameter int NUM    = 2
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [NUM-1:0]             wr,
   input  logic [DATA_W-1:0]          wdata,
   output logic [NUM-1:0][DATA_W-1:0] q
);

   for (genvar g = 0; g < NUM; g++) begin : g_word
      always_ff @(posedge clk) begin
         if (!rst_n)    q[g] <= '0;
         else if (wr[g]) q[g] <= wdata;
      end
   end

endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
   import dma_regs_pkg::*;
#(
   parameter int          DATA_W  = 32,
   parameter int          LEN_W   = 16,
   parameter logic [31:0] VERSION = CTRL_VERSION,
   parameter logic [31:0] RO_MASK = CTRL_RO_MASK
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  bus_en,
   input  logic                  bus_we,
   input  logic [BUS_ADDR_W-1:0] bus_addr,
   input  logic [3:0]            bus_strb,
   input  logic [DATA_W-1:0]     bus_wdata,
   output logic [DATA_W-1:0]     bus_rdata,
   input  logic                  dev_irq_in,
   output logic                  irq_out,
   output logic                  periph_rst,
   output logic                  dma_en_out,
   input  logic                  xfer_done,
   input  logic [LEN_W-1:0]      xfer_len,
   output logic [DATA_W-1:0]     cur_addr,
   output logic [DATA_W-1:0]     base_addr
);

   localparam int N_STORE = NUM_REGS - 2;

   if (DATA_W != 32) begin : g_bad_width
      $error("dma_chan_regs: DATA_W must be 32");
   end
   if (LEN_W < 1 || LEN_W > DATA_W) begin : g_bad_len
      $error("dma_chan_regs: LEN_W out of range");
   end

   logic                          acc_ok;
   reg_sel_e                      sel;
   logic [NUM_REGS-1:0]           wr_vec;
   logic [DATA_W-1:0]             csr_q;
   logic [N_STORE-1:0][DATA_W-1:0] store_q;
   logic [NUM_REGS-1:0][DATA_W-1:0] rd_words;

   assign acc_ok = bus_en && (bus_strb == 4'hF) && (bus_addr[1:0] == 2'b00);
   assign sel    = reg_sel_e'(bus_addr[BUS_ADDR_W-1:2]);

   for (genvar i = 0; i < NUM_REGS; i++) begin : g_wdec
      assign wr_vec[i] = acc_ok && bus_we && (sel == reg_sel_e'(i));
   end

   dma_ctrl_reg #(
      .DATA_W  (DATA_W),
      .VERSION (VERSION),
      .RO_MASK (RO_MASK)
   ) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr         (wr_vec[REG_CTRL]),
      .wdata      (bus_wdata),
      .dev_irq    (dev_irq_in),
      .loaded_set (wr_vec[REG_CURADDR]),
      .ctrl_q     (csr_q),
      .irq_out    (irq_out),
      .periph_rst (periph_rst),
      .dma_en     (dma_en_out)
   );

   dma_addr_ctr #(
      .DATA_W (DATA_W),
      .LEN_W  (LEN_W)
   ) u_addr (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr      (wr_vec[REG_CURADDR]),
      .wdata   (bus_wdata),
      .adv     (xfer_done),
      .adv_len (xfer_len),
      .addr_q  (cur_addr)
   );

   dma_store_regs #(
      .DATA_W (DATA_W),
      .NUM    (N_STORE)
   ) u_store (
      .clk   (clk),
      .rst_n (rst_n),
      .wr    (wr_vec[NUM_REGS-1:2]),
      .wdata (bus_wdata),
      .q     (store_q)
   );

   assign rd_words[REG_CTRL]    = csr_q;
   assign rd_words[REG_CURADDR] = cur_addr;
   for (genvar k = 0; k < N_STORE; k++) begin : g_rd
      assign rd_words[k+2] = store_q[k];
   end

   assign base_addr = store_q[N_STORE-1];
   assign bus_rdata = (acc_ok && !bus_we) ? rd_words[sel] : '0;

endmodule

// File: rtl/dma_chan_regs_chk.sv
module dma_chan_regs_chk #(
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_en,
   input logic              bus_we,
   input logic [3:0]        bus_addr,
   input logic [3:0]        bus_strb,
   input logic [DATA_W-1:0] bus_wdata,
   input logic              dev_irq_in,
   input logic              irq_out,
   input logic              periph_rst,
   input logic              dma_en_out,
   input logic              xfer_done,
   input logic [DATA_W-1:0] cur_addr,
   input logic [DATA_W-1:0] csr_q
);

   logic wok, wr_c, wr_a;
   assign wok  = bus_en && bus_we && (bus_strb == 4'hF) && (bus_addr[1:0] == 2'b00);
   assign wr_c = wok && (bus_addr[3:2] == 2'd0);
   assign wr_a = wok && (bus_addr[3:2] == 2'd1);

   AST_IRQ_NEEDS_DEV: assert property (@(posedge clk) disable iff (!rst_n)
      irq_out |-> $past(dev_irq_in));                                    // R4
   AST_PRST_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      periph_rst |-> $past(wr_c && bus_wdata[7]));                        // R5
   AST_EN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_c |=> $stable(dma_en_out));                                     // R7
   AST_VERSION_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (csr_q[31] && csr_q[29]));                                          // R8
   AST_LOADED_SET: assert property (@(posedge clk) disable iff (!rst_n)
      wr_a |=> csr_q[26]);                                                // R9
   AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_a && !xfer_done) |=> $stable(cur_addr));                       // R10
   AST_ADDR_BUS_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      wr_a |=> (cur_addr == $past(bus_wdata)));                           // R11

endmodule

bind dma_chan_regs dma_chan_regs_chk #(.DATA_W(DATA_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .bus_en     (bus_en),
   .bus_we     (bus_we),
   .bus_addr   (bus_addr),
   .bus_strb   (bus_strb),
   .bus_wdata  (bus_wdata),
   .dev_irq_in (dev_irq_in),
   .irq_out    (irq_out),
   .periph_rst (periph_rst),
   .dma_en_out (dma_en_out),
   .xfer_done  (xfer_done),
   .cur_addr   (cur_addr),
   .csr_q      (csr_q)
);

// File: tb/test_dma_chan_regs.sv
`timescale 1ns/1ps
module test_dma_chan_regs;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_en = 1'b0, bus_we = 1'b0;
   logic [3:0]  bus_addr = '0, bus_strb = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        dev_irq_in = 1'b0;
   logic        irq_out, periph_rst, dma_en_out;
   logic        xfer_done = 1'b0;
   logic [15:0] xfer_len = '0;
   logic [31:0] cur_addr, base_addr;

   int n_chk = 0;
   int n_bad = 0;

   always #4 clk = ~clk;

   dma_chan_regs i_dma_chan_regs (
      .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_strb(bus_strb), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .dev_irq_in(dev_irq_in), .irq_out(irq_out),
      .periph_rst(periph_rst), .dma_en_out(dma_en_out), .xfer_done(xfer_done),
      .xfer_len(xfer_len), .cur_addr(cur_addr), .base_addr(base_addr)
   );

   // control-word writes: {written value, expected readback}
   localparam logic [63:0] VEC [8] = '{
      {32'h0000_0000, 32'hA000_0040},
      {32'h0000_0040, 32'hA000_0000},
      {32'hFFFF_FFFF, 32'hA1FF_FFF8},
      {32'h0000_0010, 32'hA000_0010},
      {32'h0000_0248, 32'hA000_0208},
      {32'h0000_00C0, 32'hA000_00C0},
      {32'h5A5A_5A5A, 32'hA05A_5A18},
      {32'h0000_0001, 32'hA000_0000}
   };

   task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   task automatic wr(input logic [1:0] r, input logic [31:0] d, input logic [3:0] s = 4'hF);
      @(negedge clk);
      bus_en = 1'b1; bus_we = 1'b1; bus_addr = {r, 2'b00}; bus_strb = s; bus_wdata = d;
      @(posedge clk);
      @(negedge clk);
      bus_en = 1'b0; bus_we = 1'b0;
   endtask

   task automatic rd(input logic [1:0] r, output logic [31:0] d);
      bus_en = 1'b1; bus_we = 1'b0; bus_addr = {r, 2'b00}; bus_strb = 4'hF;
      #1 d = bus_rdata;
      bus_en = 1'b0;
   endtask

   initial begin
      logic [31:0] v;
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      // R1 reset state
      rd(2'd0, v); chk("R1 ctrl", v, 32'hA000_0000);
      rd(2'd1, v); chk("R1 addr", v, 32'h0);
      rd(2'd2, v); chk("R1 scratch", v, 32'h0);
      rd(2'd3, v); chk("R1 base", v, 32'h0);
      chk("R1 outputs", {29'b0, irq_out, periph_rst, dma_en_out}, 32'h0);

      // R6 / R8 control-word vectors
      for (int i = 0; i < 8; i++) begin
         wr(2'd0, VEC[i][63:32]);
         rd(2'd0, v);
         chk("R6/R8 ctrl vector", v, VEC[i][31:0]);
      end

      // R2 selection, full storage, partial strobes ignored
      wr(2'd2, 32'hDEAD_BEEF);
      wr(2'd3, 32'h1234_5678);
      rd(2'd2, v); chk("R2 scratch", v, 32'hDEAD_BEEF);
      rd(2'd3, v); chk("R2 base", v, 32'h1234_5678);
      chk("R2 base_addr port", base_addr, 32'h1234_5678);
      wr(2'd2, 32'h0, 4'h3);
      rd(2'd2, v); chk("R2 partial strobe ignored", v, 32'hDEAD_BEEF);

      // R7 enable edges
      wr(2'd0, 32'h0000_0200); chk("R7 en rise", {31'b0, dma_en_out}, 32'h1);
      wr(2'd0, 32'h0000_0210); chk("R7 en hold", {31'b0, dma_en_out}, 32'h1);
      wr(2'd0, 32'h0000_0010); chk("R7 en fall", {31'b0, dma_en_out}, 32'h0);

      // R3 / R4 pending and gating (bit 4 now set)
      dev_irq_in = 1'b1;
      @(negedge clk);
      rd(2'd0, v); chk("R3 pending set", {31'b0, v[0]}, 32'h1);
      chk("R4 irq asserted", {31'b0, irq_out}, 32'h1);
      wr(2'd0, 32'h0000_0020);
      chk("R4 irq dropped", {31'b0, irq_out}, 32'h0);
      rd(2'd0, v); chk("R3/R8 pending kept", v, 32'hA000_0021);
      dev_irq_in = 1'b0;
      @(negedge clk);
      rd(2'd0, v); chk("R3 pending clear", {31'b0, v[0]}, 32'h0);

      // R5 reset pulse
      wr(2'd0, 32'h0000_0080);
      chk("R5 pulse high", {31'b0, periph_rst}, 32'h1);
      @(negedge clk);
      chk("R5 pulse single", {31'b0, periph_rst}, 32'h0);

      // R9 loaded bit, R8 kept across control write
      wr(2'd1, 32'h0000_1000);
      rd(2'd0, v); chk("R9 loaded set", {31'b0, v[26]}, 32'h1);
      wr(2'd0, 32'h0);
      rd(2'd0, v); chk("R8 loaded kept", v, 32'hA400_0040);

      // R10 advance
      @(negedge clk); xfer_done = 1'b1; xfer_len = 16'h0020;
      @(negedge clk); xfer_len = 16'h0004;
      @(negedge clk); xfer_done = 1'b0;
      chk("R10 advance", cur_addr, 32'h0000_1024);
      xfer_done = 1'b1; xfer_len = 16'hFFFF;
      @(negedge clk); xfer_done = 1'b0;
      chk("R10 max len", cur_addr, 32'h0001_1023);

      // R11 bus write wins
      bus_en = 1'b1; bus_we = 1'b1; bus_addr = 4'h4; bus_strb = 4'hF;
      bus_wdata = 32'h0000_5000; xfer_done = 1'b1; xfer_len = 16'h0100;
      @(negedge clk);
      bus_en = 1'b0; bus_we = 1'b0; xfer_done = 1'b0;
      rd(2'd1, v); chk("R11 bus wins", v, 32'h0000_5000);

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      #100000;
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule